// File: doc/BRIEF.md
# Vector Mask Register Unit

This block keeps a bit-mask register whose length is one vector section (`SECT_BITS` bits, 128 by default). A vector-length input sets how many leading positions are active for each command. Position 0 is the first element.

A command is a start pulse together with an opcode and a vector length. Four commands work on the register alone: uniformity test, complement, leading-zero count and population count. Five commands merge a stream of memory bytes into the active positions: load, load inverted, AND, OR and XOR. The stream arrives one byte per cycle on a valid/data pair. Every command ends with a one-cycle done pulse. It returns a 2-bit condition code and a 32-bit count, which stay valid until the next command finishes. A command that writes the register always leaves every position at or above the vector length cleared.

The controller is a four-state machine:
- `ST_IDLE` waits for start. On start it moves to `ST_FETCH` for a memory command that needs at least one byte. Otherwise it moves to `ST_EXEC`.
- `ST_FETCH` merges one byte on each valid cycle. It moves to `ST_EXEC` on the edge that accepts the last byte.
- `ST_EXEC` computes the register result, the condition code and the count, then moves to `ST_FINISH`.
- `ST_FINISH` drives done and returns to `ST_IDLE`.

Top module: `vmr_unit`

## Requirements
- R1: After reset the register is all zero, cc and count are 0, and done and busy are low.
- R2: Start is accepted only while busy is low; a start while busy has no effect. Busy is high from the edge that takes start until the machine returns to idle. Done is high for exactly one cycle. For a register-only command, done is high in the second cycle after the start edge.
- R3: `mask_bits[i]` is position i. Stream byte k supplies positions 8k to 8k+7, with byte bit 7 landing at position 8k and byte bit 0 at position 8k+7.
- R4: Test (opcode 0) gives cc 0 when all active positions are zero, cc 3 when all are one, and cc 1 when they are mixed. It leaves the register unchanged.
- R5: Count-ones (opcode 3) returns the number of set active positions, with the same cc rule as test.
- R6: Leading-zero count (opcode 2) returns the number of zero positions before the first set active position, or the vector length if none is set. Its cc is 3 when position 0 is set, 1 when the first set position is later, and 0 when none is set.
- R7: With a vector length of 0, commands 0, 2 and 3 return cc 0 and count 0 and leave the register unchanged.
- R8: Complement (opcode 1) inverts the active positions.
- R9: Load (opcode 4) and load inverted (opcode 5) consume exactly ceil(length/8) stream bytes and write the data, or its inverse, into the active positions. A length of 0 consumes no byte and clears the register.
- R10: AND (6), OR (7) and XOR (8) combine each active position with the matching stream bit.
- R11: Every writing command (1, 4 to 8) clears all positions at or above the vector length, including the unused bits of a partial last byte.
- R12: A writing command reports the cc (by the test rule) and the ones count of its own result.
- R13: Commands 0, 2 and 3 never modify the register, even when positions beyond the current length are set.
- R14: Cycles with byte_valid low during a fetch are stalls. Bytes offered while no fetch is running are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command request |
| opcode | input | 4 | Command code (see requirements) |
| vcount | input | $clog2(SECT_BITS+1) | Active vector length, 0 to SECT_BITS |
| byte_valid | input | 1 | Stream byte present |
| byte_data | input | 8 | Stream byte |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| cc | output | 2 | Condition code |
| count | output | 32 | Count result |
| mask_bits | output | SECT_BITS | Register contents, index = position |

## Verification
The assertions assume three things about the inputs:
- `vcount` never exceeds the section size when a start is taken.
- Start is only meaningful while the unit is idle.
- The byte stream never supplies more bytes than the active length covers.

The stimulus keeps within these limits. It uses lengths from 0 to 128 and feeds exactly the bytes each command needs. It issues start while busy only to show that the request is dropped. Stray bytes are sent only while the unit is idle, where they must be ignored.

// File: rtl/vmr_pkg.sv
package vmr_pkg;

    typedef enum logic [3:0] {
        OP_TEST  = 4'd0,
        OP_COMP  = 4'd1,
        OP_LZC   = 4'd2,
        OP_POPC  = 4'd3,
        OP_LOAD  = 4'd4,
        OP_LOADN = 4'd5,
        OP_AND   = 4'd6,
        OP_OR    = 4'd7,
        OP_XOR   = 4'd8
    } vmr_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FETCH  = 2'd1,
        ST_EXEC   = 2'd2,
        ST_FINISH = 2'd3
    } vmr_state_e;

    function automatic logic op_uses_stream(input logic [3:0] op);
        return (op >= 4'd4) && (op <= 4'd8);
    endfunction

    function automatic logic op_writes(input logic [3:0] op);
        return (op == 4'd1) || op_uses_stream(op);
    endfunction

endpackage

// File: rtl/vmr_byte_merge.sv
module vmr_byte_merge
    import vmr_pkg::*;
(
    input  logic [3:0] op,
    input  logic [7:0] cur,
    input  logic [7:0] stream,
    output logic [7:0] result
);

    logic [7:0] din;

    // stream bit 7 feeds the lowest position of the byte
    always_comb begin
        for (int j = 0; j < 8; j++) begin
            din[j] = stream[7 - j];
        end
    end

    always_comb begin
        unique case (op)
            OP_LOAD:  result = din;
            OP_LOADN: result = ~din;
            OP_AND:   result = cur & din;
            OP_OR:    result = cur | din;
            OP_XOR:   result = cur ^ din;
            default:  result = cur;
        endcase
    end

endmodule

// File: rtl/vmr_stat.sv
module vmr_stat #(
    parameter int SB = 128,
    parameter int CW = 8
) (
    input  logic [SB-1:0] bits,
    input  logic [CW-1:0] vlen,
    output logic [SB-1:0] live,
    output logic          none_set,
    output logic          all_set,
    output logic [CW-1:0] ones,
    output logic [CW-1:0] lead
);

    always_comb begin
        for (int i = 0; i < SB; i++) begin
            live[i] = (CW'(i) < vlen);
        end
    end

    always_comb begin
        ones = '0;
        for (int i = 0; i < SB; i++) begin
            ones = ones + CW'(bits[i] & live[i]);
        end
    end

    // downward scan so the lowest set position wins
    always_comb begin
        lead = vlen;
        for (int i = SB - 1; i >= 0; i--) begin
            if (bits[i] && live[i]) lead = CW'(i);
        end
    end

    assign none_set = ((bits & live) == '0);
    assign all_set  = ((bits | ~live) == '1);

endmodule

// File: rtl/vmr_unit.sv
module vmr_unit
    import vmr_pkg::*;
#(
    parameter int SECT_BITS = 128,
    localparam int CW = $clog2(SECT_BITS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [3:0]           opcode,
    input  logic [CW-1:0]        vcount,
    input  logic                 byte_valid,
    input  logic [7:0]           byte_data,
    output logic                 busy,
    output logic                 done,
    output logic [1:0]           cc,
    output logic [31:0]          count,
    output logic [SECT_BITS-1:0] mask_bits
);

    localparam int NB = SECT_BITS / 8;
    localparam int IW = (NB > 1) ? $clog2(NB) : 1;

    vmr_state_e           state_q, state_nx;
    logic [3:0]           op_q;
    logic [CW-1:0]        vc_q;
    logic [SECT_BITS-1:0] mask_q;
    logic [IW-1:0]        idx_q, last_q;
    logic [1:0]           cc_q;
    logic [31:0]          cnt_q;

    logic [CW:0]          need_w;
    logic                 writes_q;
    logic [7:0]           cur_byte, merged;
    logic [SECT_BITS-1:0] fetch_next, exec_base, exec_result, stat_src, live;
    logic                 none_set, all_set;
    logic [CW-1:0]        ones, lead;

    assign need_w   = ({1'b0, vcount} + (CW + 1)'(7)) >> 3;
    assign writes_q = op_writes(op_q);
    assign cur_byte = mask_q[8*idx_q +: 8];

    vmr_byte_merge u_merge (
        .op     (op_q),
        .cur    (cur_byte),
        .stream (byte_data),
        .result (merged)
    );

    always_comb begin
        fetch_next = mask_q;
        fetch_next[8*idx_q +: 8] = merged;
    end

    assign exec_base   = (op_q == OP_COMP) ? ~mask_q : mask_q;
    assign exec_result = exec_base & live;
    assign stat_src    = writes_q ? exec_result : mask_q;

    vmr_stat #(.SB(SECT_BITS), .CW(CW)) u_stat (
        .bits     (stat_src),
        .vlen     (vc_q),
        .live     (live),
        .none_set (none_set),
        .all_set  (all_set),
        .ones     (ones),
        .lead     (lead)
    );

    // next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_nx = (op_uses_stream(opcode) && need_w != '0) ? ST_FETCH : ST_EXEC;
            ST_FETCH:  if (byte_valid && idx_q == last_q) state_nx = ST_EXEC;
            ST_EXEC:   state_nx = ST_FINISH;
            ST_FINISH: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= '0;
            vc_q   <= '0;
            mask_q <= '0;
            idx_q  <= '0;
            last_q <= '0;
            cc_q   <= '0;
            cnt_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    op_q   <= opcode;
                    vc_q   <= vcount;
                    idx_q  <= '0;
                    last_q <= IW'(need_w - (CW + 1)'(1));
                end
                ST_FETCH: if (byte_valid) begin
                    mask_q <= fetch_next;
                    idx_q  <= idx_q + IW'(1);
                end
                ST_EXEC: begin
                    if (writes_q) mask_q <= exec_result;
                    if (op_q == OP_LZC) begin
                        cnt_q <= 32'(lead);
                        cc_q  <= none_set ? 2'd0 : (mask_q[0] ? 2'd3 : 2'd1);
                    end else begin
                        cnt_q <= 32'(ones);
                        cc_q  <= none_set ? 2'd0 : (all_set ? 2'd3 : 2'd1);
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        done      = (state_q == ST_FINISH);
        cc        = cc_q;
        count     = cnt_q;
        mask_bits = mask_q;
    end

    a_r2_vc_range: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state_q == ST_IDLE) |-> (vcount <= CW'(SECT_BITS)));

    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> $stable(mask_q));

    a_r11_tail_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FINISH && writes_q) |-> ((mask_q & ~live) == '0));

    a_r13_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXEC && !writes_q) |=> $stable(mask_q));

    a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cnt_q <= 32'(vc_q)));

    a_r7_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
        (done && vc_q == '0) |-> (cc_q == 2'd0 && cnt_q == 32'd0));

endmodule

// File: tb/vmr_unit_test.sv
`timescale 1ns/1ps
module vmr_unit_test;
    import vmr_pkg::*;

    localparam int SB = 128;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [3:0]    opcode = '0;
    logic [CW-1:0] vcount = '0;
    logic          byte_valid = 1'b0;
    logic [7:0]    byte_data = '0;
    logic          busy, done;
    logic [1:0]    cc;
    logic [31:0]   count;
    logic [SB-1:0] mask_bits;

    always #4 clk = ~clk;

    vmr_unit #(.SECT_BITS(SB)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .vcount(vcount),
        .byte_valid(byte_valid), .byte_data(byte_data), .busy(busy), .done(done),
        .cc(cc), .count(count), .mask_bits(mask_bits)
    );

    typedef struct {
        logic [1:0]    cc;
        logic [31:0]   cnt;
        logic [SB-1:0] m;
        string         tag;
    } exp_t;

    exp_t          expq[$];
    exp_t          got;
    logic [SB-1:0] model = '0;
    logic [7:0]    src [0:15];
    int            total = 0;
    int            bad = 0;

    task automatic chk(input bit ok, input string tag, input logic [SB-1:0] act, input logic [SB-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pop one expected item per done pulse
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R2 unexpected done", 1, 0);
            end else begin
                got = expq.pop_front();
                chk(cc == got.cc, {got.tag, " cc"}, SB'(cc), SB'(got.cc));
                chk(count == got.cnt, {got.tag, " count"}, SB'(count), SB'(got.cnt));
                chk(mask_bits == got.m, {got.tag, " mask"}, mask_bits, got.m);
            end
        end
    end

    task automatic fill(input logic [7:0] seed, input logic [7:0] step);
        for (int k = 0; k < 16; k++) src[k] = seed + 8'(k) * step;
    endtask

    // independent reference for cc and count
    task automatic predict(input logic [3:0] op, input int vc, output logic [1:0] pcc, output logic [31:0] pcnt);
        int n1 = 0;
        int first = -1;
        for (int i = 0; i < vc; i++) begin
            if (model[i]) begin
                n1++;
                if (first < 0) first = i;
            end
        end
        if (vc == 0) begin
            pcc = 2'd0; pcnt = 0;
        end else if (op == OP_LZC) begin
            if (first < 0) begin pcc = 2'd0; pcnt = vc; end
            else begin pcc = (first == 0) ? 2'd3 : 2'd1; pcnt = first; end
        end else begin
            pcnt = n1;
            pcc = (n1 == 0) ? 2'd0 : ((n1 == vc) ? 2'd3 : 2'd1);
        end
    endtask

    task automatic run(input logic [3:0] op, input int vc, input int stall, input string tag);
        exp_t e;
        int nb = (vc + 7) / 8;
        bit mem = (op >= 4 && op <= 8);
        bit wr = mem || (op == OP_COMP);
        if (op == OP_COMP) for (int i = 0; i < vc; i++) model[i] = ~model[i];
        if (mem) begin
            for (int k = 0; k < nb; k++) begin
                for (int j = 0; j < 8; j++) begin
                    logic d = src[k][7 - j];
                    int p = 8 * k + j;
                    case (op)
                        OP_LOAD:  model[p] = d;
                        OP_LOADN: model[p] = ~d;
                        OP_AND:   model[p] = model[p] & d;
                        OP_OR:    model[p] = model[p] | d;
                        default:  model[p] = model[p] ^ d;
                    endcase
                end
            end
        end
        if (wr) for (int i = vc; i < SB; i++) model[i] = 1'b0;
        predict(op, vc, e.cc, e.cnt);
        e.m = model;
        e.tag = tag;
        expq.push_back(e);
        @(negedge clk);
        start = 1'b1; opcode = op; vcount = CW'(vc);
        @(negedge clk);
        start = 1'b0;
        if (mem) begin
            for (int k = 0; k < nb; k++) begin
                if (stall > 0 && k == 1) begin
                    for (int s = 0; s < stall; s++) begin
                        byte_valid = 1'b0; start = 1'b1; opcode = OP_COMP;
                        @(negedge clk);
                    end
                    start = 1'b0; opcode = op;
                end
                byte_valid = 1'b1; byte_data = src[k];
                @(negedge clk);
            end
            byte_valid = 1'b0;
        end
        while (expq.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mask_bits == '0, "R1 mask", mask_bits, '0);
        chk(cc == 2'd0, "R1 cc", SB'(cc), '0);
        chk(count == 32'd0, "R1 count", SB'(count), '0);
        chk(!done, "R1 done", SB'(done), '0);
        chk(!busy, "R1 busy", SB'(busy), '0);

        // R2 latency of a register-only command
        begin
            exp_t e;
            e.cc = 2'd0; e.cnt = 0; e.m = model; e.tag = "R2 latency";
            expq.push_back(e);
            @(negedge clk);
            start = 1'b1; opcode = OP_TEST; vcount = 8'd8;
            @(negedge clk);
            start = 1'b0;
            chk(busy && !done, "R2 busy first cycle", SB'({busy, done}), SB'(2'b10));
            @(negedge clk);
            chk(done, "R2 done second cycle", SB'(done), SB'(1));
            while (expq.size() != 0) @(negedge clk);
            @(negedge clk);
        end

        fill(8'h80, 8'h00); run(OP_LOAD, 8, 0, "R3 msb to pos0");
        fill(8'h01, 8'h00); run(OP_LOAD, 8, 0, "R3 lsb to pos7");
        fill(8'h3C, 8'h51); run(OP_LOAD, 128, 0, "R9 load full");
        run(OP_TEST, 128, 0, "R4 mixed");
        run(OP_POPC, 128, 0, "R5 ones");
        run(OP_COMP, 13, 0, "R8 R11 R12 complement");
        fill(8'hFF, 8'h00); run(OP_LOAD, 20, 0, "R9 load ones");
        run(OP_TEST, 20, 0, "R4 all one");
        run(OP_LOADN, 20, 0, "R9 load inverted");
        run(OP_TEST, 20, 0, "R4 all zero");
        fill(8'h00, 8'h00); src[2] = 8'h10; src[3] = 8'hC3; src[4] = 8'h01;
        run(OP_LOAD, 40, 0, "R9 partial");
        run(OP_LZC, 40, 0, "R6 first later");
        run(OP_LZC, 16, 0, "R6 none set");
        fill(8'h80, 8'h00); run(OP_LOAD, 1, 0, "R9 single");
        run(OP_LZC, 1, 0, "R6 bit0");
        fill(8'hA5, 8'h11); run(OP_LOAD, 128, 0, "R9 reload");
        run(OP_TEST, 0, 0, "R7 test");
        run(OP_LZC, 0, 0, "R7 lzc");
        run(OP_POPC, 0, 0, "R7 popc");
        fill(8'h0F, 8'h23); run(OP_AND, 128, 0, "R10 R12 and");
        fill(8'h91, 8'h35); run(OP_OR, 77, 0, "R10 R11 or");
        fill(8'h6E, 8'h17); run(OP_XOR, 100, 3, "R10 R14 R2 xor stall");
        run(OP_LOAD, 0, 0, "R9 zero bytes");
        fill(8'hFF, 8'h00); run(OP_LOAD, 128, 0, "R9 all ones");
        run(OP_TEST, 4, 0, "R13 short test");
        run(OP_POPC, 128, 0, "R13 tail kept");

        // R14 stray bytes while idle
        @(negedge clk);
        byte_valid = 1'b1; byte_data = 8'h00;
        repeat (3) @(negedge clk);
        byte_valid = 1'b0;
        run(OP_POPC, 128, 0, "R14 idle bytes ignored");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule